// File: doc/BRIEF.md
# Cascaded Second-Order-Section IIR Filter

This block is a sixth-order recursive low-pass filter built as three identical second-order sections wired in series. Each section evaluates its own two-pole, two-zero difference equation on signed 16-bit samples, using five signed coefficients that arrive on runtime input ports. The coefficients are real values scaled by 2^24. The same logic therefore serves any coefficient set the surrounding system supplies.

A sample enters on a one-cycle valid strobe. The first section computes its result over five clock cycles with one shared multiplier. It then hands the result and a one-cycle strobe to the next section. The result of the last section is the filter output. Every section shows a busy flag while it works. A strobe that arrives while the first section is busy is dropped. With a 100 MHz clock and a new sample every 64 cycles, each section finishes long before the next sample is due.

Top module: `iir_sos_cascade`

## Requirements
- R1: Each section k computes y[n] = b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]. The leading denominator coefficient is fixed at 1. Section k takes its coefficients from bits [k*32 +: 32] of coef_b0, coef_b1, coef_b2, coef_a1 and coef_a2. Section 0 is fed by in_sample, and section k+1 is fed by the output of section k.
- R2: Coefficients are signed two's-complement values equal to the real coefficient times 2^24. The sum of the five products is shifted right arithmetically by 24 bits, which rounds toward minus infinity.
- R3: After the shift, a result above 32767 becomes 32767 and a result below −32768 becomes −32768. The saturated value is both the section output and the value stored as y[n-1].
- R4: A strobe on in_valid is taken only when busy[0] is low. A strobe taken while busy[0] is high leaves every output and every history register unchanged.
- R5: busy[k] goes high on the clock edge that accepts a sample into section k. It stays high for exactly five cycles and falls on the edge that writes the result.
- R6: Each section raises its valid output for exactly one cycle, on the edge where its busy flag falls. The next section accepts that strobe on the following edge.
- R7: out_valid is high for exactly one cycle. It is seen high 17 clock edges after the edge that accepted the sample at in_valid.
- R8: When rst_n is low at a clock edge, all history registers, accumulators, busy flags and valid strobes are cleared, and out_sample reads 0.
- R9: Samples presented every 6 cycles are all processed, in order, with none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_sample | input | 16 | Signed input sample |
| coef_b0 | input | 96 | Per-section b0 coefficient, section k at bits [k*32 +: 32] |
| coef_b1 | input | 96 | Per-section b1 coefficient |
| coef_b2 | input | 96 | Per-section b2 coefficient |
| coef_a1 | input | 96 | Per-section a1 coefficient (subtracted) |
| coef_a2 | input | 96 | Per-section a2 coefficient (subtracted) |
| out_sample | output | 16 | Signed filter output, held until the next result |
| out_valid | output | 1 | One-cycle strobe marking a new out_sample |
| busy | output | 3 | Per-section flag, high while that section computes |

## Verification
A table drives a pure one-sample delay with a halving gain through the chain. It checks the routing of the tap delays and the rounding of odd negative values toward minus infinity. It also checks the inputs at the full-scale extremes. A second set of coefficients, with real feedback and a gain of two in the last section, is fed a pseudo-random stream at the fastest rate the filter allows. The result is compared with an independent model, which separates sign or order errors in the a-terms from lost or reordered samples. Directed patterns follow:
- Overdriven inputs show that saturation is applied before the y[n-1] register is written.
- A strobe inside the busy window shows that it is dropped without disturbing the history.
- A mid-stream reset shows that all history registers are cleared.

// File: rtl/iir_sos_pkg.sv
// Package: shared types for the cascaded second-order-section filter.
// Assumes: a single shared multiplier walks the five taps in this fixed order.
package iir_sos_pkg;

    // Order in which a section visits its five product terms
    typedef enum logic [2:0] {
        TAP_X0 = 3'd0,
        TAP_X1 = 3'd1,
        TAP_X2 = 3'd2,
        TAP_Y1 = 3'd3,
        TAP_Y2 = 3'd4
    } tap_e;

endpackage

// File: rtl/sos_tap_select.sv
// Module: sos_tap_select
// Picks the coefficient and the history sample for the current tap. It also
// flags whether that product is subtracted, which is true for the feedback terms.
// Assumes: the tap code is one of the five package values; other codes give zero.
module sos_tap_select
    import iir_sos_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 32
) (
    input  tap_e                     tap,
    input  logic signed [COEF_W-1:0] k_b0,
    input  logic signed [COEF_W-1:0] k_b1,
    input  logic signed [COEF_W-1:0] k_b2,
    input  logic signed [COEF_W-1:0] k_a1,
    input  logic signed [COEF_W-1:0] k_a2,
    input  logic signed [DATA_W-1:0] h_x0,
    input  logic signed [DATA_W-1:0] h_x1,
    input  logic signed [DATA_W-1:0] h_x2,
    input  logic signed [DATA_W-1:0] h_y1,
    input  logic signed [DATA_W-1:0] h_y2,
    output logic signed [COEF_W-1:0] sel_coef,
    output logic signed [DATA_W-1:0] sel_data,
    output logic                     sel_neg
);

    // Route one coefficient/sample pair to the multiplier
    always_comb begin
        sel_coef = '0;
        sel_data = '0;
        sel_neg  = 1'b0;
        case (tap)
            TAP_X0: begin sel_coef = k_b0; sel_data = h_x0; end
            TAP_X1: begin sel_coef = k_b1; sel_data = h_x1; end
            TAP_X2: begin sel_coef = k_b2; sel_data = h_x2; end
            TAP_Y1: begin sel_coef = k_a1; sel_data = h_y1; sel_neg = 1'b1; end
            TAP_Y2: begin sel_coef = k_a2; sel_data = h_y2; sel_neg = 1'b1; end
            default: begin sel_coef = '0; sel_data = '0; sel_neg = 1'b0; end
        endcase
    end

endmodule

// File: rtl/sos_mac.sv
// Module: sos_mac
// Multiplies a sample by a coefficient, sign-extends the product to the
// accumulator width, and adds it to or subtracts it from the running sum.
// Assumes: ACC_W is wide enough for five full-scale products (ACC_W >= PROD_W + 3).
module sos_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 32,
    parameter int ACC_W  = 64
) (
    input  logic signed [ACC_W-1:0]  acc_in,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [DATA_W-1:0] data,
    input  logic                     negate,
    output logic signed [ACC_W-1:0]  acc_out
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;

    // One signed product, widened with its sign bit
    always_comb begin
        prod     = coef * data;
        prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
    end

    // Add or subtract the widened product
    always_comb begin
        if (negate) begin
            acc_out = acc_in - prod_ext;
        end else begin
            acc_out = acc_in + prod_ext;
        end
    end

endmodule

// File: rtl/sos_requant.sv
// Module: sos_requant
// Turns the fixed-point sum back into a sample. It shifts right arithmetically
// by FRAC_W bits (rounding toward minus infinity) and then clamps to the signed
// DATA_W range.
// Assumes: ACC_W > FRAC_W + DATA_W.
module sos_requant #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 64,
    parameter int FRAC_W = 24
) (
    input  logic signed [ACC_W-1:0]  sum,
    output logic signed [DATA_W-1:0] sample
);

    localparam int HI_W = ACC_W - DATA_W + 1;

    logic signed [ACC_W-1:0] shifted;
    logic        [HI_W-1:0]  upper;
    logic                    in_range;

    // Drop the fraction bits, keeping the sign
    always_comb begin
        shifted  = sum >>> FRAC_W;
        upper    = shifted[ACC_W-1:DATA_W-1];
        in_range = (upper == '0) || (upper == '1);
    end

    // Clamp to the largest or smallest sample when the upper bits disagree
    always_comb begin
        if (in_range) begin
            sample = shifted[DATA_W-1:0];
        end else if (shifted[ACC_W-1]) begin
            sample = {1'b1, {(DATA_W-1){1'b0}}};
        end else begin
            sample = {1'b0, {(DATA_W-1){1'b1}}};
        end
    end

endmodule

// File: rtl/biquad_section.sv
// Module: biquad_section
// One two-pole, two-zero section. A sample is taken on a one-cycle strobe
// while the section is idle. Five product terms are accumulated, one per
// cycle, through a single multiplier. The fifth cycle rescales and saturates
// the sum, writes the output, pulses valid_out, drops busy and shifts the
// x/y history.
// Assumes: coefficients are steady while a sample is in flight; strobes
// arriving while busy are dropped.
module biquad_section
    import iir_sos_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 32,
    parameter int ACC_W  = 64,
    parameter int FRAC_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_in,
    input  logic signed [DATA_W-1:0] din,
    input  logic signed [COEF_W-1:0] k_b0,
    input  logic signed [COEF_W-1:0] k_b1,
    input  logic signed [COEF_W-1:0] k_b2,
    input  logic signed [COEF_W-1:0] k_a1,
    input  logic signed [COEF_W-1:0] k_a2,
    output logic signed [DATA_W-1:0] dout,
    output logic                     valid_out,
    output logic                     busy
);

    tap_e                     tap;
    tap_e                     tap_nxt;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_nxt;
    logic signed [DATA_W-1:0] x0, x1, x2, y1, y2;
    logic signed [COEF_W-1:0] sel_coef;
    logic signed [DATA_W-1:0] sel_data;
    logic                     sel_neg;
    logic signed [DATA_W-1:0] result;
    logic                     last_tap;

    sos_tap_select #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W)
    ) u_sel (
        .tap      (tap),
        .k_b0     (k_b0),
        .k_b1     (k_b1),
        .k_b2     (k_b2),
        .k_a1     (k_a1),
        .k_a2     (k_a2),
        .h_x0     (x0),
        .h_x1     (x1),
        .h_x2     (x2),
        .h_y1     (y1),
        .h_y2     (y2),
        .sel_coef (sel_coef),
        .sel_data (sel_data),
        .sel_neg  (sel_neg)
    );

    sos_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W)
    ) u_mac (
        .acc_in  (acc),
        .coef    (sel_coef),
        .data    (sel_data),
        .negate  (sel_neg),
        .acc_out (acc_nxt)
    );

    sos_requant #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W)
    ) u_rq (
        .sum    (acc_nxt),
        .sample (result)
    );

    // Next tap in the fixed visiting order
    always_comb begin
        last_tap = 1'b0;
        case (tap)
            TAP_X0:  tap_nxt = TAP_X1;
            TAP_X1:  tap_nxt = TAP_X2;
            TAP_X2:  tap_nxt = TAP_Y1;
            TAP_Y1:  tap_nxt = TAP_Y2;
            default: begin tap_nxt = TAP_X0; last_tap = 1'b1; end
        endcase
    end

    // Accept, accumulate, then write back and shift the history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap       <= TAP_X0;
            acc       <= '0;
            busy      <= 1'b0;
            valid_out <= 1'b0;
            dout      <= '0;
            x0        <= '0;
            x1        <= '0;
            x2        <= '0;
            y1        <= '0;
            y2        <= '0;
        end else begin
            valid_out <= 1'b0;
            if (!busy) begin
                if (valid_in) begin
                    x0   <= din;
                    acc  <= '0;
                    tap  <= TAP_X0;
                    busy <= 1'b1;
                end
            end else if (last_tap) begin
                dout      <= result;
                valid_out <= 1'b1;
                busy      <= 1'b0;
                acc       <= '0;
                tap       <= TAP_X0;
                x2        <= x1;
                x1        <= x0;
                y2        <= y1;
                y1        <= result;
            end else begin
                acc <= acc_nxt;
                tap <= tap_nxt;
            end
        end
    end

endmodule

// File: rtl/iir_sos_cascade.sv
// Module: iir_sos_cascade (top)
// Chains NSEC identical second-order sections. Each section's data and valid
// strobe feed the next one; the last section drives the filter output.
// Coefficients come in as flat vectors, section k at bits [k*COEF_W +: COEF_W].
// Assumes: the input strobe lasts one cycle; samples closer together than
// the section period (6 cycles) are partly dropped.
module iir_sos_cascade #(
    parameter int NSEC   = 3,
    parameter int DATA_W = 16,
    parameter int COEF_W = 32,
    parameter int ACC_W  = 64,
    parameter int FRAC_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic [NSEC*COEF_W-1:0]   coef_b0,
    input  logic [NSEC*COEF_W-1:0]   coef_b1,
    input  logic [NSEC*COEF_W-1:0]   coef_b2,
    input  logic [NSEC*COEF_W-1:0]   coef_a1,
    input  logic [NSEC*COEF_W-1:0]   coef_a2,
    output logic signed [DATA_W-1:0] out_sample,
    output logic                     out_valid,
    output logic [NSEC-1:0]          busy
);

    localparam int LINKS = NSEC + 1;

    logic signed [DATA_W-1:0] link_data  [LINKS];
    logic                     link_valid [LINKS];

    // Feed the head of the chain from the block inputs
    always_comb begin
        link_data[0]  = in_sample;
        link_valid[0] = in_valid;
    end

    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        biquad_section #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .ACC_W  (ACC_W),
            .FRAC_W (FRAC_W)
        ) u_sec (
            .clk       (clk),
            .rst_n     (rst_n),
            .valid_in  (link_valid[k]),
            .din       (link_data[k]),
            .k_b0      (coef_b0[k*COEF_W +: COEF_W]),
            .k_b1      (coef_b1[k*COEF_W +: COEF_W]),
            .k_b2      (coef_b2[k*COEF_W +: COEF_W]),
            .k_a1      (coef_a1[k*COEF_W +: COEF_W]),
            .k_a2      (coef_a2[k*COEF_W +: COEF_W]),
            .dout      (link_data[k+1]),
            .valid_out (link_valid[k+1]),
            .busy      (busy[k])
        );
    end

    // Tail of the chain is the filter output
    always_comb begin
        out_sample = link_data[NSEC];
        out_valid  = link_valid[NSEC];
    end

endmodule

// File: rtl/iir_sos_cascade_checks.sv
// Module: iir_sos_cascade_checks
// Port-level timing properties of the cascade: strobe widths, the busy
// window length and the hand-off between sections. Attached by bind.
// Assumes: NSEC >= 2.
module iir_sos_cascade_checks #(
    parameter int NSEC = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [NSEC-1:0] busy,
    input logic            out_valid
);

    // R7: the output strobe never lasts two cycles
    assert_out_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4/R5: the first section only starts on an input strobe
    assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy[0]) |-> $past(in_valid));

    // R5: a busy window lasts exactly five cycles
    assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy[0]) |-> ($past(busy[0], 5) && !$past(busy[0], 6)));

    // R6: when the first section finishes, the second one starts
    assert_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy[0]) |=> busy[1]);

    // R6: the output strobe coincides with the last section finishing
    assert_out_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $fell(busy[NSEC-1]));

endmodule

bind iir_sos_cascade iir_sos_cascade_checks #(.NSEC(NSEC)) i_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid)
);

// File: tb/test_iir_sos_cascade.sv
`timescale 1ns/1ps
module test_iir_sos_cascade;

    localparam int NSEC = 3;
    localparam int DW   = 16;
    localparam int CW   = 32;
    localparam longint ONE = 64'sd16777216;   // 1.0 in Q24

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic [NSEC*CW-1:0] coef_b0 = '0, coef_b1 = '0, coef_b2 = '0, coef_a1 = '0, coef_a2 = '0;
    logic signed [DW-1:0] out_sample;
    logic              out_valid;
    logic [NSEC-1:0]   busy;

    int n_run = 0;
    int n_fail = 0;

    int     cb0 [NSEC], cb1 [NSEC], cb2 [NSEC], ca1 [NSEC], ca2 [NSEC];
    longint mx1 [NSEC], mx2 [NSEC], my1 [NSEC], my2 [NSEC];

    // Delay-and-halve table: out[n] = floor(in[n-1] / 2)
    localparam logic signed [DW-1:0] TV_IN  [8] = '{16'sd100, -16'sd200, 16'sd32767, -16'sd32768,
                                                   16'sd7, -16'sd7, 16'sd0, 16'sd1000};
    localparam logic signed [DW-1:0] TV_EXP [8] = '{16'sd0, 16'sd50, -16'sd100, 16'sd16383,
                                                   -16'sd16384, 16'sd3, -16'sd4, 16'sd0};

    iir_sos_cascade #(.NSEC(NSEC)) i_iir_sos_cascade (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .coef_b0    (coef_b0),
        .coef_b1    (coef_b1),
        .coef_b2    (coef_b2),
        .coef_a1    (coef_a1),
        .coef_a2    (coef_a2),
        .out_sample (out_sample),
        .out_valid  (out_valid),
        .busy       (busy)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_cfg();
        for (int k = 0; k < NSEC; k++) begin
            coef_b0[k*CW +: CW] = cb0[k];
            coef_b1[k*CW +: CW] = cb1[k];
            coef_b2[k*CW +: CW] = cb2[k];
            coef_a1[k*CW +: CW] = ca1[k];
            coef_a2[k*CW +: CW] = ca2[k];
        end
    endtask

    task automatic clear_cfg();
        for (int k = 0; k < NSEC; k++) begin
            cb0[k] = 0; cb1[k] = 0; cb2[k] = 0; ca1[k] = 0; ca2[k] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NSEC; k++) begin
            mx1[k] = 0; mx2[k] = 0; my1[k] = 0; my2[k] = 0;
        end
    endtask

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Independent reference of the whole chain for one sample
    function automatic longint model_run(input longint x);
        longint v = x;
        for (int k = 0; k < NSEC; k++) begin
            longint s;
            longint y;
            s = longint'(cb0[k]) * v + longint'(cb1[k]) * mx1[k] + longint'(cb2[k]) * mx2[k]
              - longint'(ca1[k]) * my1[k] - longint'(ca2[k]) * my2[k];
            y = sat16(s >>> 24);
            mx2[k] = mx1[k]; mx1[k] = v;
            my2[k] = my1[k]; my1[k] = y;
            v = y;
        end
        return v;
    endfunction

    // Present one sample for one cycle; returns on the negedge after acceptance
    task automatic send(input logic signed [DW-1:0] s);
        @(negedge clk);
        in_sample = s;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic wait_out(output logic signed [DW-1:0] val, output int lat);
        lat = 0;
        while (!out_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        val = out_sample;
        if (!out_valid) check(1'b0, "timeout", lat, 17);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic signed [DW-1:0] got;
        int lat;
        int cnt;

        // R8: reset state
        clear_cfg(); load_cfg();
        do_reset();
        check(out_valid == 1'b0, "R8 out_valid at reset", out_valid, 0);
        check(out_sample == 0, "R8 out_sample at reset", out_sample, 0);
        check(busy == '0, "R8 busy at reset", busy, 0);

        // R1/R2 table: section 0 unity, section 1 one-sample delay, section 2 half
        clear_cfg();
        cb0[0] = int'(ONE); cb1[1] = int'(ONE); cb0[2] = int'(ONE / 2);
        load_cfg();
        for (int i = 0; i < 8; i++) begin
            send(TV_IN[i]);
            wait_out(got, lat);
            check(got == TV_EXP[i], "R1 R2 table", got, TV_EXP[i]);
            if (i == 0) check(lat == 17, "R7 latency", lat, 17);
            @(negedge clk);
            check(out_valid == 1'b0, "R7 out strobe width", out_valid, 0);
            repeat (50) @(negedge clk);
        end

        // R5: busy window of section 0 and hand-off to section 1
        send(16'sd10);
        cnt = 0;
        while (busy[0] && cnt < 50) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == 5, "R5 busy length", cnt, 5);
        check(busy[1] == 1'b0, "R6 section1 not yet busy", busy[1], 0);
        @(negedge clk);
        check(busy[1] == 1'b1, "R6 section1 busy after hand-off", busy[1], 1);
        wait_out(got, lat);
        repeat (10) @(negedge clk);

        // R4: strobe while busy is dropped and leaves history intact
        do_reset();
        send(16'sd1000);
        check(busy[0] == 1'b1, "R4 busy during drop", busy[0], 1);
        in_sample = 16'sd5000;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        wait_out(got, lat);
        check(got == 0, "R4 first output", got, 0);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (out_valid) cnt++;
        end
        check(cnt == 0, "R4 no extra output", cnt, 0);
        send(16'sd3000);
        wait_out(got, lat);
        check(got == 500, "R4 history kept", got, 500);
        repeat (10) @(negedge clk);

        // R8: mid-stream reset clears history
        send(16'sd2222);
        wait_out(got, lat);
        do_reset();
        check(out_sample == 0, "R8 output after reset", out_sample, 0);
        send(16'sd1234);
        wait_out(got, lat);
        check(got == 0, "R8 history cleared", got, 0);
        repeat (10) @(negedge clk);

        // R3: saturation and saturated y[n-1]: y = 4x - 0.5*y1 in section 0
        clear_cfg();
        cb0[0] = int'(4 * ONE); ca1[0] = int'(ONE / 2);
        cb0[1] = int'(ONE); cb0[2] = int'(ONE);
        load_cfg();
        do_reset();
        send(16'sd20000);
        wait_out(got, lat);
        check(got == 32767, "R3 positive clamp", got, 32767);
        repeat (10) @(negedge clk);
        send(16'sd0);
        wait_out(got, lat);
        check(got == -16384, "R3 saturated history", got, -16384);
        repeat (10) @(negedge clk);
        do_reset();
        send(-16'sd20000);
        wait_out(got, lat);
        check(got == -32768, "R3 negative clamp", got, -32768);
        repeat (10) @(negedge clk);

        // R1/R9: feedback coefficients, stream at one sample every 6 cycles
        clear_cfg();
        for (int k = 0; k < NSEC; k++) begin
            cb0[k] = 4194304; cb1[k] = 8388608; cb2[k] = 4194304;
            ca1[k] = -10066330; ca2[k] = 3355443;
        end
        cb0[2] = 33554432; cb1[2] = 0; cb2[2] = 0;
        load_cfg();
        do_reset();
        begin
            logic signed [DW-1:0] stim [24];
            longint expv [24];
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 24; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                stim[i] = $signed(lf);
                expv[i] = model_run(longint'(stim[i]));
            end
            fork
                begin
                    for (int i = 0; i < 24; i++) begin
                        send(stim[i]);
                        repeat (4) @(negedge clk);
                    end
                end
                begin
                    for (int i = 0; i < 24; i++) begin
                        wait_out(got, lat);
                        check(got == expv[i], "R9 R1 streamed result", got, expv[i]);
                        @(negedge clk);
                    end
                end
            join
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule